// File: doc/BRIEF.md
# Program Bank Address Mapper

This block sits between a CPU and a program ROM. It turns each CPU read address in the 0x6000–0xFFFF range into a physical ROM address and raises a ROM-select flag. The CPU programs the mapping with ordinary bus writes. Four 8-bit bank numbers and one layout control byte set how the 32 KB upper area is cut into windows: two 16 KB windows, four 8 KB windows, or three 8 KB windows with the top window fixed to the last bank. In the last case a fifth 8 KB window can also be opened at 0x6000.

The translated address and the select flag are registered. They appear one clock after the read address is presented. A write takes effect for reads presented in the cycle after the write.

Top module: `prg_bank_mapper`

## Requirements
- R1: After a synchronous reset, every bank number is 0xFF and the control byte is 0xFF, which selects layout 3. The outputs rom_sel and rom_addr are 0 for the first cycle after reset.
- R2: A write to bank number i (0..3) occurs when (wr_addr AND 0xF007) equals 0x8000+i. This means that aliases such as 0x8FF9 write bank 1, while 0x8004 writes nothing.
- R3: Any write with wr_addr[15:12] = 0xD and wr_addr[1:0] = 0 loads the layout control. In that control, bits 1:0 are the layout, bit 2 is the four-window flag and bit 7 enables the low window. Writes in 0xD000–0xDFFF with wr_addr[1:0] != 0 leave the layout unchanged.
- R4: In layout 1, 0x8000–0xBFFF maps 16 KB bank number 0 and 0xC000–0xFFFF maps 16 KB bank number 2.
- R5: In layouts 0 and 3, the 8 KB windows at 0x8000, 0xA000, 0xC000 and 0xE000 map bank numbers 0, 1, 2 and 3.
- R6: In layout 2 with control bit 2 set, the four 8 KB windows map bank numbers 0 to 3, as in R5.
- R7: In layout 2 with control bit 2 clear, 0x8000–0xDFFF map bank numbers 0 to 2 and 0xE000–0xFFFF maps the all-ones bank.
- R8: In layout 2 with bit 2 clear and bit 7 set, 0x6000–0x7FFF maps bank number 3 with rom_sel = 1. In every other setting, reads there give rom_sel = 0.
- R9: rom_sel is 1 for every read at 0x8000–0xFFFF. It is 0 for reads below 0x6000. rom_addr is 0 whenever rom_sel is 0.
- R10: rom_addr equals bank × window size + offset in the window (8 KB or 16 KB), truncated to ROM_AW bits. Bank bits above the ROM size are therefore dropped.
- R11: rom_addr and rom_sel reflect the rd_addr presented one clock earlier.
- R12: A cycle with wr_en low, or a write to any other address (for example 0x5800, 0x9000, 0xC000), changes no bank number and no control bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| rd_addr | input | 16 | CPU read address to translate |
| rom_addr | output | ROM_AW | Registered program ROM address |
| rom_sel | output | 1 | Registered ROM-select flag |

## Verification
The assertions check the following on every cycle:
- write decoding into each bank number and into the control bits;
- register hold when no write occurs;
- the power-up control value;
- rom_sel being forced low under 0x6000 and high above 0x8000;
- the in-window offset being carried through;
- the all-ones top window in the fixed layout.

Only the bench scenarios can show that the correct bank reaches each window in each of the four layouts. This covers the 16 KB pairing, the alias and ignore cases of the write decode, the opening and closing of the 0x6000 window, and truncation of wide bank numbers. The bench checks these against a reference model built from the requirements.

// File: rtl/prg_map_pkg.sv
// Package: shared constants and types for the program bank mapper.
// Assumes an 8-bit CPU data bus and a 16-bit CPU address bus.
package prg_map_pkg;
    localparam int CPU_AW    = 16;
    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 4;
    localparam int WIN8_BITS = 13;   // 8 KB window offset width
    localparam int WIN16_BITS = 14;  // 16 KB window offset width

    // Write decode constants
    localparam logic [CPU_AW-1:0] BANK_MASK = 16'hF007;
    localparam logic [CPU_AW-1:0] BANK_BASE = 16'h8000;
    localparam logic [3:0]        CTRL_PAGE = 4'hD;

    typedef enum logic [1:0] {
        LAY_QUAD_A = 2'd0,
        LAY_PAIR16 = 2'd1,
        LAY_FIXTOP = 2'd2,
        LAY_QUAD_B = 2'd3
    } layout_e;

    typedef struct packed {
        logic    low_win;  // written from data bit 7
        logic    all_quad; // written from data bit 2
        layout_e layout;   // written from data bits 1:0
    } prg_ctrl_t;

    typedef logic [NUM_BANKS-1:0][BANK_W-1:0] bank_arr_t;
endpackage

// File: rtl/prg_map_regs.sv
// Module: CPU-writable bank numbers and layout control.
// Decodes single-cycle writes. Bank numbers use the 0xF007 address mask.
// Layout control is any write in the 0xD page with address bits 1:0 at zero.
// Assumes wr_en is high for one cycle per CPU write.
module prg_map_regs
    import prg_map_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  logic [BANK_W-1:0] wr_data,
    output bank_arr_t         bank_q,
    output prg_ctrl_t         ctrl_q
);
    logic [CPU_AW-1:0] masked_addr;
    logic              ctrl_hit;

    // Purpose: apply the bank decode mask and detect a layout control write.
    always_comb begin
        masked_addr = wr_addr & BANK_MASK;
        ctrl_hit    = wr_en && (wr_addr[15:12] == CTRL_PAGE) && (wr_addr[1:0] == 2'b00);
    end

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
        logic hit;
        assign hit = wr_en && (masked_addr == (BANK_BASE + CPU_AW'(i)));

        // Purpose: hold one bank number, loaded when its address matches.
        always_ff @(posedge clk) begin
            if (!rst_n)   bank_q[i] <= '1;
            else if (hit) bank_q[i] <= wr_data;
        end

        assert_bank_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && ((wr_addr & 16'hF007) == (16'h8000 + 16'(i))))
            |=> (bank_q[i] == $past(wr_data)));
    end

    // Purpose: hold the layout control bits that the translator uses.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= '1;
        else if (ctrl_hit)
            ctrl_q <= '{low_win: wr_data[7], all_quad: wr_data[2],
                        layout: layout_e'(wr_data[1:0])};
    end

    assert_ctrl_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:12] == 4'hD && wr_addr[1:0] == 2'b00)
        |=> (ctrl_q == {$past(wr_data[7]), $past(wr_data[2]), $past(wr_data[1:0])}));

    assert_hold_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> ($stable(bank_q) && $stable(ctrl_q)));

    assert_power_up_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (ctrl_q == 4'hF));
endmodule

// File: rtl/prg_map_xlate.sv
// Module: combinational translation of a CPU read address into a ROM address.
// Assumes ROM_AW is between 14 and 22. Bank bits that exceed ROM_AW are dropped.
module prg_map_xlate
    import prg_map_pkg::*;
#(
    parameter int ROM_AW = 19
) (
    input  logic [CPU_AW-1:0] cpu_addr,
    input  bank_arr_t         banks,
    input  prg_ctrl_t         ctrl,
    output logic              hit,
    output logic [ROM_AW-1:0] addr
);
    logic [1:0]        win;
    logic [BANK_W-1:0] sel_bank;
    logic              use16;

    assign win = cpu_addr[14:13];

    // Purpose: pick the bank and window size for the addressed window.
    always_comb begin
        sel_bank = '0;
        use16    = 1'b0;
        hit      = 1'b0;
        if (cpu_addr[15]) begin
            hit = 1'b1;
            unique case (ctrl.layout)
                LAY_PAIR16: begin
                    use16    = 1'b1;
                    sel_bank = cpu_addr[14] ? banks[2] : banks[0];
                end
                LAY_FIXTOP: begin
                    if (!ctrl.all_quad && win == 2'd3) sel_bank = '1;
                    else                               sel_bank = banks[win];
                end
                default: sel_bank = banks[win];
            endcase
        end else if (win == 2'd3) begin
            if (ctrl.layout == LAY_FIXTOP && !ctrl.all_quad && ctrl.low_win) begin
                hit      = 1'b1;
                sel_bank = banks[3];
            end
        end
    end

    // Purpose: join the bank and offset, truncate to the ROM width, zero when unmapped.
    always_comb begin
        if (!hit)
            addr = '0;
        else if (use16)
            addr = ROM_AW'({sel_bank, cpu_addr[WIN16_BITS-1:0]});
        else
            addr = ROM_AW'({sel_bank, cpu_addr[WIN8_BITS-1:0]});
    end
endmodule

// File: rtl/prg_bank_mapper.sv
// Module: top of the program bank mapper.
// Holds the write-side registers, translates rd_addr and registers the result.
// Assumes outputs are sampled one clock after rd_addr is presented.
module prg_bank_mapper
    import prg_map_pkg::*;
#(
    parameter int ROM_AW = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [15:0]       rd_addr,
    output logic [ROM_AW-1:0] rom_addr,
    output logic              rom_sel
);
    localparam int KEEP8 = (ROM_AW - WIN8_BITS < BANK_W) ? (ROM_AW - WIN8_BITS) : BANK_W;

    bank_arr_t         banks;
    prg_ctrl_t         ctrl;
    logic              nxt_hit;
    logic [ROM_AW-1:0] nxt_addr;

    prg_map_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .bank_q  (banks),
        .ctrl_q  (ctrl)
    );

    prg_map_xlate #(.ROM_AW(ROM_AW)) u_xlate (
        .cpu_addr (rd_addr),
        .banks    (banks),
        .ctrl     (ctrl),
        .hit      (nxt_hit),
        .addr     (nxt_addr)
    );

    // Purpose: register the translated address and select flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rom_addr <= '0;
            rom_sel  <= 1'b0;
        end else begin
            rom_addr <= nxt_addr;
            rom_sel  <= nxt_hit;
        end
    end

    assert_low_unmapped_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr < 16'h6000) |=> (!rom_sel && rom_addr == '0));

    assert_upper_selected_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr[15] |=> rom_sel);

    assert_offset_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_addr[15] |=> (rom_addr[12:0] == $past(rd_addr[12:0])));

    assert_fixed_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.layout == LAY_FIXTOP && !ctrl.all_quad && rd_addr[15:13] == 3'b111)
        |=> (&rom_addr[WIN8_BITS +: KEEP8]));
endmodule

// File: tb/sim_prg_bank_mapper.sv
`timescale 1ns/1ps
module sim_prg_bank_mapper;
    localparam int ROM_AW = 19;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [15:0]       wr_addr = '0;
    logic [7:0]        wr_data = '0;
    logic [15:0]       rd_addr = '0;
    logic [ROM_AW-1:0] rom_addr;
    logic              rom_sel;

    int errors = 0;
    int checks = 0;

    // Reference state, kept from the requirements
    logic [7:0] m_bank [4];
    logic [7:0] m_ctrl;

    logic [ROM_AW:0] exp_q [$];
    string           tag_q [$];

    always #2.5 clk = ~clk;

    prg_bank_mapper #(.ROM_AW(ROM_AW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rom_addr(rom_addr), .rom_sel(rom_sel)
    );

    function automatic logic [ROM_AW:0] model(input logic [15:0] a);
        logic [1:0]  lay;
        logic [7:0]  bank;
        logic [31:0] full;
        logic        sel;
        lay  = m_ctrl[1:0];
        sel  = 1'b0;
        full = 0;
        if (a[15]) begin
            sel = 1'b1;
            if (lay == 2'd1) begin
                bank = a[14] ? m_bank[2] : m_bank[0];
                full = 32'(bank) * 32'd16384 + 32'(a[13:0]);
            end else begin
                if (lay == 2'd2 && !m_ctrl[2] && a[14:13] == 2'd3) bank = 8'hFF;
                else bank = m_bank[a[14:13]];
                full = 32'(bank) * 32'd8192 + 32'(a[12:0]);
            end
        end else if (a >= 16'h6000) begin
            if (lay == 2'd2 && !m_ctrl[2] && m_ctrl[7]) begin
                sel  = 1'b1;
                full = 32'(m_bank[3]) * 32'd8192 + 32'(a[12:0]);
            end
        end
        return {sel, full[ROM_AW-1:0]};
    endfunction

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if ((a & 16'hF007) >= 16'h8000 && (a & 16'hF007) <= 16'h8003)
            m_bank[a[1:0]] = d;
        if (a[15:12] == 4'hD && a[1:0] == 2'b00)
            m_ctrl = d;
    endtask

    task automatic idle_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b0; wr_addr = a; wr_data = d;
    endtask

    task automatic rd(input logic [15:0] a, input string tag);
        @(negedge clk);
        wr_en = 1'b0; rd_addr = a;
        exp_q.push_back(model(a));
        tag_q.push_back(tag);
    endtask

    // Monitor: compare one result per read, one clock after it was driven (R11)
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            logic [ROM_AW:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if ({rom_sel, rom_addr} !== e) begin
                errors++;
                $display("FAIL %s: got sel=%0b addr=%h, expected sel=%0b addr=%h",
                         t, rom_sel, rom_addr, e[ROM_AW], e[ROM_AW-1:0]);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: got timeout, expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) m_bank[i] = 8'hFF;
        m_ctrl = 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (rom_sel !== 1'b0 || rom_addr !== '0) begin
            errors++;
            $display("FAIL R1: got sel=%0b addr=%h, expected sel=0 addr=0", rom_sel, rom_addr);
        end
        // R1: power-up layout 3 with all-ones banks
        rd(16'h8000, "R1 reset 0x8000");
        rd(16'hE001, "R1 reset 0xE001");
        rd(16'h6000, "R8 reset low window closed");
        rd(16'h5FFF, "R9 below 0x6000");
        // R5: layout 0, four 8 KB windows
        wr(16'hD000, 8'h00);
        wr(16'h8000, 8'h01); wr(16'h8001, 8'h02); wr(16'h8002, 8'h03); wr(16'h8003, 8'h04);
        rd(16'h8123, "R5 window 0");
        rd(16'hA456, "R5 window 1");
        rd(16'hC789, "R5 window 2");
        rd(16'hFFFF, "R5 window 3");
        rd(16'h7000, "R9 low window in layout 0");
        // R2: aliases and non-matching bank addresses; R10 truncation
        wr(16'h8FF9, 8'h45);
        wr(16'h8004, 8'h77);
        rd(16'hA000, "R2 alias 0x8FF9 loads bank 1, R10 truncated");
        rd(16'h8000, "R2 0x8004 ignored");
        // R3: control byte at nonzero index ignored
        wr(16'hD001, 8'h01);
        rd(16'hC000, "R3 index 1 ignored");
        // R4: layout 1 via an aliased control address
        wr(16'hDAB0, 8'h01);
        rd(16'h8000, "R4 lower 16 KB start");
        rd(16'hBFFF, "R4 lower 16 KB end");
        rd(16'hC000, "R4 upper 16 KB start");
        rd(16'hFFFE, "R4 upper 16 KB end");
        wr(16'h8002, 8'hB7);
        rd(16'hD234, "R10 16 KB bank truncated");
        // R5: layout 3
        wr(16'hD000, 8'h03);
        rd(16'hE555, "R5 layout 3 window 3");
        // R6: layout 2 with four-window flag
        wr(16'hD000, 8'h06);
        rd(16'hE010, "R6 window 3 uses bank 3");
        rd(16'h6010, "R8 closed with four-window flag");
        // R7: layout 2 fixed top
        wr(16'hD000, 8'h02);
        rd(16'hE010, "R7 fixed top");
        rd(16'hA010, "R7 window 1");
        rd(16'h6010, "R8 low window closed");
        // R8: low window enabled
        wr(16'hD000, 8'h82);
        rd(16'h6ABC, "R8 low window bank 3");
        rd(16'h7FFF, "R8 low window end");
        rd(16'h5000, "R9 below 0x6000 with low window");
        // R12: other writes and idle strobes
        wr(16'h5800, 8'h00);
        wr(16'h9000, 8'h00);
        wr(16'hC000, 8'h00);
        idle_wr(16'h8003, 8'h00);
        idle_wr(16'hD000, 8'h01);
        rd(16'h6ABC, "R12 low window unchanged");
        rd(16'h8000, "R12 bank 0 unchanged");
        rd(16'hC000, "R12 bank 2 unchanged");
        rd(16'hF000, "R11 back-to-back read");
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule